// File: doc/BRIEF.md
# Flushable Ready/Valid FIFO Queue

This block is a synchronous first-in first-out queue with a valid/ready handshake on its write side and on its read side. It also reports how many entries it holds. A one-cycle synchronous flush input throws away everything stored. The queue is then empty on the next clock, whatever it held before. Parameters set the data width and the depth. The depth can be any value of one or more and need not be a power of two. A third parameter selects how entries are stored: in an array read through logic, or in an array with a registered read port. The two storage choices behave the same at the ports.

A flush may arrive in the same cycle as a write or a read, and the block defines the result of each case:

- A write accepted in a flush cycle is dropped.
- A read accepted in a flush cycle still delivers the current head entry.
- Every entry left after that read is discarded.

A synchronous reset leaves the queue in the same state as a flush.

Top module: `flush_fifo`

## Requirements
- R1: After reset, `count` is 0, `enq_ready` is 1 and `deq_valid` is 0.
- R2: With `flush` low, entries leave on `deq_data` in exactly the order they were accepted on `enq_data`.
- R3: `count` never exceeds DEPTH. `enq_ready` is 0 exactly when `count` equals DEPTH. `deq_valid` is 0 exactly when `count` is 0. Without a flush, an accepted read alone lowers `count` by one, and a write is accepted only when `enq_ready` is 1.
- R4: A cycle with both an accepted write and an accepted read, and `flush` low, leaves `count` unchanged in the next cycle.
- R5: In the cycle after `flush` is high, `count` is 0, `deq_valid` is 0 and `enq_ready` is 1, even if the queue was full.
- R6: A write accepted in the same cycle as `flush` is discarded and never appears on `deq_data`.
- R7: While `flush` is high and the queue is not empty, `deq_valid` stays 1. A read accepted in that cycle delivers the current head entry.
- R8: Read and write positions wrap modulo DEPTH, so ordering holds over many wraps when DEPTH is not a power of two (default 5).
- R9: With STORE set to registered-read storage or to combinational-read storage, `count`, `enq_ready`, `deq_valid` and, while valid, `deq_data` are identical for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous discard of all stored entries |
| enq_valid | input | 1 | Write request |
| enq_ready | output | 1 | Queue can accept a write |
| enq_data | input | W | Write data |
| deq_valid | output | 1 | Head entry is present |
| deq_ready | input | 1 | Consumer takes the head entry |
| deq_data | output | W | Head entry |
| count | output | $clog2(DEPTH+1) | Number of stored entries, 0 to DEPTH |

## Verification
A wrong occupancy value shows at the ports one cycle after the bad update. `enq_ready`, `deq_valid` and `count` then disagree with the scoreboard's item total. A read or write position that is wrongly advanced, or that does not wrap, shows up as a wrong or repeated `deq_data` value. It appears on the next accepted read that reaches the damaged slot. At a depth of five, that is at most five reads later. A fault in the registered read port or its same-address bypass shows as a mismatch between the two storage variants. It appears on the first read of an entry that was written while the queue was empty.

// File: rtl/fq_pkg.sv
package fq_pkg;
   typedef enum logic {
      STORE_REG  = 1'b0,
      STORE_COMB = 1'b1
   } store_e;

   function automatic int ptr_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/fq_ptr.sv
module fq_ptr #(
   parameter int DEPTH = 5,
   parameter int PW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          adv,
   output logic [PW-1:0] ptr,
   output logic [PW-1:0] ptr_nxt
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [PW-1:0] ptr_inc;

   assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;

   always_comb begin
      if (clr)      ptr_nxt = '0;
      else if (adv) ptr_nxt = ptr_inc;
      else          ptr_nxt = ptr;
   end

   always_ff @(posedge clk) begin
      if (rst) ptr <= '0;
      else     ptr <= ptr_nxt;
   end

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
      ptr <= LAST); // R8
endmodule

// File: rtl/fq_store.sv
module fq_store #(
   parameter int             W     = 8,
   parameter int             DEPTH = 5,
   parameter int             PW    = 3,
   parameter fq_pkg::store_e STORE = fq_pkg::STORE_REG
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [PW-1:0] raddr,
   input  logic [PW-1:0] raddr_nxt,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (STORE == fq_pkg::STORE_COMB) begin : g_comb
      assign rdata = mem[raddr];
   end else begin : g_reg
      logic [W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (we && (waddr == raddr_nxt)) rd_q <= wdata;
         else                            rd_q <= mem[raddr_nxt];
      end
      assign rdata = rd_q;
   end
endmodule

// File: rtl/fq_ctrl.sv
module fq_ctrl #(
   parameter int DEPTH = 5,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush,
   input  logic          enq_fire,
   input  logic          deq_fire,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam logic [CW-1:0] CMAX = CW'(DEPTH);

   logic [CW-1:0] count_nxt;

   always_comb begin
      count_nxt = count;
      if (flush)                     count_nxt = '0;
      else if (enq_fire && !deq_fire) count_nxt = count + 1'b1;
      else if (deq_fire && !enq_fire) count_nxt = count - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) count <= '0;
      else     count <= count_nxt;
   end

   assign full  = (count == CMAX);
   assign empty = (count == '0);

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      count <= CMAX); // R3
endmodule

// File: rtl/flush_fifo.sv
module flush_fifo #(
   parameter int             W     = 8,
   parameter int             DEPTH = 5,
   parameter fq_pkg::store_e STORE = fq_pkg::STORE_REG,
   localparam int            CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush,
   input  logic          enq_valid,
   output logic          enq_ready,
   input  logic [W-1:0]  enq_data,
   output logic          deq_valid,
   input  logic          deq_ready,
   output logic [W-1:0]  deq_data,
   output logic [CW-1:0] count
);
   localparam int PW = fq_pkg::ptr_width(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("flush_fifo: DEPTH must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("flush_fifo: W must be at least 1");
   end

   logic          full, empty;
   logic          enq_fire, deq_fire;
   logic [PW-1:0] wr_ptr, wr_ptr_nxt;
   logic [PW-1:0] rd_ptr, rd_ptr_nxt;

   assign enq_ready = !full;
   assign deq_valid = !empty;
   assign enq_fire  = enq_valid && enq_ready;
   assign deq_fire  = deq_valid && deq_ready;

   fq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
      .clk(clk), .rst(rst), .flush(flush),
      .enq_fire(enq_fire), .deq_fire(deq_fire),
      .count(count), .full(full), .empty(empty)
   );

   fq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
      .clk(clk), .rst(rst), .clr(flush), .adv(enq_fire),
      .ptr(wr_ptr), .ptr_nxt(wr_ptr_nxt)
   );

   fq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
      .clk(clk), .rst(rst), .clr(flush), .adv(deq_fire),
      .ptr(rd_ptr), .ptr_nxt(rd_ptr_nxt)
   );

   fq_store #(.W(W), .DEPTH(DEPTH), .PW(PW), .STORE(STORE)) u_store (
      .clk(clk), .we(enq_fire && !flush), .waddr(wr_ptr), .wdata(enq_data),
      .raddr(rd_ptr), .raddr_nxt(rd_ptr_nxt), .rdata(deq_data)
   );

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      flush |=> (count == '0) && enq_ready && !deq_valid); // R5

   AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (rst)
      (enq_fire && deq_fire && !flush) |=> $stable(count)); // R4

   AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (rst)
      (deq_fire && !enq_fire && !flush) |=> (count == $past(count) - 1'b1)); // R3

   AST_FLUSH_VALID: assert property (@(posedge clk) disable iff (rst)
      (flush && (count != '0)) |-> deq_valid); // R7
endmodule

// File: tb/flush_fifo_tb.sv
module flush_fifo_tb;
   localparam int W     = 8;
   localparam int DEPTH = 5;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          flush = 1'b0;
   logic          enq_valid = 1'b0;
   logic [W-1:0]  enq_data = '0;
   logic          deq_ready = 1'b0;
   logic          enq_ready, deq_valid, enq_ready_c, deq_valid_c;
   logic [W-1:0]  deq_data, deq_data_c;
   logic [CW-1:0] count, count_c;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   int  model [$];
   bit  after_flush = 1'b0;
   bit  hold_pend = 1'b0;
   int  hold_cnt = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   flush_fifo #(.W(W), .DEPTH(DEPTH), .STORE(fq_pkg::STORE_REG)) u_dut (
      .clk(clk), .rst(rst), .flush(flush),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_data(enq_data),
      .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_data(deq_data),
      .count(count)
   );

   flush_fifo #(.W(W), .DEPTH(DEPTH), .STORE(fq_pkg::STORE_COMB)) u_dut_c (
      .clk(clk), .rst(rst), .flush(flush),
      .enq_valid(enq_valid), .enq_ready(enq_ready_c), .enq_data(enq_data),
      .deq_valid(deq_valid_c), .deq_ready(deq_ready), .deq_data(deq_data_c),
      .count(count_c)
   );

   task automatic chk(input bit ok, input string tg, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("[TB] FAIL %s actual=%0d expected=%0d at %0t", tg, act, exp, $time);
      end
   endtask

   // driver and monitor for one cycle: apply inputs, compare against scoreboard, advance
   task automatic step(input logic ev, input logic [W-1:0] ed, input logic dr,
                       input logic fl, input string tg);
      bit efire, dfire;
      int exp;
      enq_valid = ev; enq_data = ed; deq_ready = dr; flush = fl;
      #1;
      if (hold_pend) chk(int'(count) == hold_cnt, "R4", int'(count), hold_cnt);
      chk(int'(count) == model.size(), after_flush ? "R5" : "R3", int'(count), model.size());
      chk(deq_valid == (model.size() != 0), after_flush ? "R5" : "R3",
          int'(deq_valid), int'(model.size() != 0));
      chk(enq_ready == (model.size() != DEPTH), after_flush ? "R5" : "R3",
          int'(enq_ready), int'(model.size() != DEPTH));
      chk(count_c == count && deq_valid_c == deq_valid && enq_ready_c == enq_ready,
          "R9", int'(count_c), int'(count));
      if (deq_valid && deq_valid_c)
         chk(deq_data_c == deq_data, "R9", int'(deq_data_c), int'(deq_data));
      if (fl && model.size() != 0) chk(deq_valid == 1'b1, "R7", int'(deq_valid), 1);
      dfire = dr && (model.size() != 0);
      efire = ev && (model.size() != DEPTH);
      if (dfire) begin
         exp = model.pop_front();
         chk(int'(deq_data) == exp, tg, int'(deq_data), exp);
      end
      if (fl) model.delete();
      else if (efire) model.push_back(int'(ed));
      hold_pend = efire && dfire && !fl;
      hold_cnt = int'(count);
      after_flush = fl;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      #1;
      chk(count == '0, "R1", int'(count), 0);
      chk(enq_ready == 1'b1, "R1", int'(enq_ready), 1);
      chk(deq_valid == 1'b0, "R1", int'(deq_valid), 0);
      @(posedge clk); #1;

      // fill past depth, then drain: order and full/empty flags
      for (int i = 0; i < DEPTH + 2; i++) step(1'b1, W'(8'h10 + i), 1'b0, 1'b0, "R2");
      for (int i = 0; i < DEPTH + 1; i++) step(1'b0, '0, 1'b1, 1'b0, "R2");

      // simultaneous write and read keep occupancy
      step(1'b1, 8'h21, 1'b0, 1'b0, "R4");
      step(1'b1, 8'h22, 1'b0, 1'b0, "R4");
      for (int i = 0; i < 6; i++) step(1'b1, W'(8'h30 + i), 1'b1, 1'b0, "R4");
      step(1'b0, '0, 1'b1, 1'b0, "R4");
      step(1'b0, '0, 1'b1, 1'b0, "R4");

      // flush while full with a write pending: write dropped, queue empty after
      for (int i = 0; i < DEPTH; i++) step(1'b1, W'(8'h40 + i), 1'b0, 1'b0, "R5");
      step(1'b1, 8'h4F, 1'b0, 1'b1, "R5");
      step(1'b0, '0, 1'b1, 1'b0, "R5");

      // flush with a read: head delivered, rest discarded
      for (int i = 0; i < 3; i++) step(1'b1, W'(8'h50 + i), 1'b0, 1'b0, "R7");
      step(1'b0, '0, 1'b1, 1'b1, "R7");
      step(1'b1, 8'h58, 1'b0, 1'b0, "R7");
      step(1'b0, '0, 1'b1, 1'b0, "R7");

      // flush with a write into an empty queue: write discarded
      step(1'b1, 8'h61, 1'b0, 1'b1, "R6");
      step(1'b1, 8'h62, 1'b0, 1'b0, "R6");
      step(1'b0, '0, 1'b1, 1'b0, "R6");
      step(1'b0, '0, 1'b1, 1'b0, "R6");

      // pseudo-random traffic over many wraps, rare flushes
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], lfsr[15:8], lfsr[1] | lfsr[2], (lfsr[7:3] == 5'd0), "R8");
      end
      for (int i = 0; i < DEPTH + 1; i++) step(1'b0, '0, 1'b1, 1'b0, "R8");

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("[TB] FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule